// File: doc/BRIEF.md
# Temperature Limit Alert with Consecutive-Reading Filter

This block watches a stream of signed temperature readings. Each reading arrives with a one-cycle valid strobe and is compared with a programmable upper limit and a programmable lower limit. A reading above the upper limit is a high violation. A reading below the lower limit is a low violation. Each direction has its own sticky status bit, and the combined alert output is raised while either status bit is set.

An optional filter guards against spurious alerts from single noisy readings. While the filter is on, a direction's status bit is set only when that direction has been violated on a run of consecutive readings, three by default. An in-limit reading breaks the run. Software turns the filter on or off at runtime by writing a one-bit enable. The enable is off after reset, so by default every violating reading is reported at once.

Status bits stay set until a clear strobe arrives. A bit is cleared by that strobe only when the most recent reading no longer violates that direction.

Top module: `temp_alert_queue`

## Requirements
- R1: After reset, `stat_hi`, `stat_lo` and `alert` are 0 and the filter enable is 0.
- R2: With the filter off, one reading that violates a limit sets the matching status bit. The bit is visible in the cycle after the valid strobe.
- R3: Violations are strict and use two's-complement compares. A reading equal to a limit is not a violation. Readings and limits are `TEMP_W`-bit signed values.
- R4: With the filter on, a direction's status bit is set on the third consecutive violating reading of that direction (`RUN_LEN`), and not on an earlier one.
- R5: An in-limit reading resets that direction's run. The high run and the low run are counted independently.
- R6: Turning the filter off resets both runs. The next violating reading then sets its status bit unfiltered.
- R7: Status bits are sticky. A pulse on `clr_stb` clears a bit only if the most recent reading did not violate that direction. `alert` is the OR of both status bits.
- R8: A cycle with `cfg_we` high loads `cfg_wdata` into the filter enable, where 1 means on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Strobe marking a new reading |
| rd_temp | input | TEMP_W | Signed reading |
| lim_hi | input | TEMP_W | Signed upper limit |
| lim_lo | input | TEMP_W | Signed lower limit |
| cfg_we | input | 1 | Write strobe for the filter enable |
| cfg_wdata | input | 1 | Filter enable value, 1 = on |
| clr_stb | input | 1 | Request to clear status bits whose condition is gone |
| stat_hi | output | 1 | Latched high-limit status |
| stat_lo | output | 1 | Latched low-limit status |
| alert | output | 1 | OR of both status bits |

## Verification
The hardest situation to reach is the filter being turned off while a run is partly counted. The stimulus turns the filter on and sends two violating readings, so the run sits one short of firing. It then writes the enable to 0 and sends a single violating reading. That reading must set the status bit at once, which shows the partial run was discarded and not carried over. A second hard case is a broken run: two violations, then an in-limit reading, then two more violations. No status bit may be set, because no three violations were consecutive.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum int {DIR_HI = 0, DIR_LO = 1} tq_dir_e;
  localparam int NUM_DIR = 2;
endpackage

// File: rtl/tq_compare.sv
module tq_compare #(
  parameter int TEMP_W = 8
) (
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] hi_i,
  input  logic [TEMP_W-1:0] lo_i,
  output logic              over_o,
  output logic              under_o
);
  function automatic logic above(input logic [TEMP_W-1:0] a, input logic [TEMP_W-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  assign over_o  = above(temp_i, hi_i);
  assign under_o = above(lo_i, temp_i);
endmodule

// File: rtl/tq_filter.sv
module tq_filter #(
  parameter int RUN_LEN = 3,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             viol_i,
  input  logic             qen_i,
  input  logic             clr_i,
  output logic             stat_o,
  output logic             event_o,
  output logic             last_o,
  output logic [CNT_W-1:0] run_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] run_q;
  logic             last_q;
  logic             stat_q;
  logic             full;

  assign full    = (run_q == FULL);
  assign event_o = valid_i && viol_i && (!qen_i || full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (!qen_i)
        run_q <= '0;
      else if (valid_i)
        run_q <= viol_i ? (full ? run_q : run_q + 1'b1) : '0;
      if (valid_i)
        last_q <= viol_i;
      if (event_o)
        stat_q <= 1'b1;
      else if (clr_i && !last_q)
        stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign last_o = last_q;
  assign run_o  = run_q;
endmodule

// File: rtl/temp_alert_queue.sv
module temp_alert_queue #(
  parameter int TEMP_W  = 8,
  parameter int RUN_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [TEMP_W-1:0] rd_temp,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic              cfg_we,
  input  logic              cfg_wdata,
  input  logic              clr_stb,
  output logic              stat_hi,
  output logic              stat_lo,
  output logic              alert
);
  import tq_pkg::*;
  localparam int CNT_W = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);

  logic queue_on;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      queue_on <= 1'b0;
    else if (cfg_we) queue_on <= cfg_wdata;
  end

  logic [NUM_DIR-1:0]            viol;
  logic [NUM_DIR-1:0]            stat;
  logic [NUM_DIR-1:0]            evt;
  logic [NUM_DIR-1:0]            last;
  logic [NUM_DIR-1:0][CNT_W-1:0] run;

  tq_compare #(.TEMP_W(TEMP_W)) u_cmp (
    .temp_i (rd_temp),
    .hi_i   (lim_hi),
    .lo_i   (lim_lo),
    .over_o (viol[DIR_HI]),
    .under_o(viol[DIR_LO])
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    tq_filter #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid_i(rd_valid),
      .viol_i (viol[d]),
      .qen_i  (queue_on),
      .clr_i  (clr_stb),
      .stat_o (stat[d]),
      .event_o(evt[d]),
      .last_o (last[d]),
      .run_o  (run[d])
    );
  end

  wire [CNT_W-1:0] hi_cnt   = run[DIR_HI];
  wire [CNT_W-1:0] lo_cnt   = run[DIR_LO];
  wire             hi_last  = last[DIR_HI];
  wire             hi_event = evt[DIR_HI];
  wire             lo_event = evt[DIR_LO];
  wire             lo_last  = last[DIR_LO];

  assign stat_hi = stat[DIR_HI];
  assign stat_lo = stat[DIR_LO];
  assign alert   = |stat;
endmodule

// File: rtl/tq_checker.sv
module tq_checker #(
  parameter int TEMP_W  = 8,
  parameter int RUN_LEN = 3,
  parameter int CNT_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic [TEMP_W-1:0] rd_temp,
  input logic [TEMP_W-1:0] lim_hi,
  input logic [TEMP_W-1:0] lim_lo,
  input logic              clr_stb,
  input logic              queue_on,
  input logic              stat_hi,
  input logic              stat_lo,
  input logic [CNT_W-1:0]  hi_cnt,
  input logic [CNT_W-1:0]  lo_cnt,
  input logic              hi_last,
  input logic              hi_event,
  input logic              lo_event,
  input logic              lo_last
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN - 1);

  // R1
  set_needs_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_hi) || $rose(stat_lo)) |-> $past(rd_valid));
  // R2
  unfiltered_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !queue_on && $signed(rd_temp) > $signed(lim_hi)) |=> stat_hi);
  // R3
  equal_not_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_temp == lim_hi && !stat_hi) |=> !stat_hi);
  // R4
  early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (queue_on && rd_valid && hi_cnt != FULL && !stat_hi) |=> !stat_hi);
  // R4
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt <= FULL) && (lo_cnt <= FULL));
  // R5
  inlimit_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !($signed(rd_temp) < $signed(lim_lo))) |=> (lo_cnt == '0));
  // R6
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_on |=> (hi_cnt == '0 && lo_cnt == '0));
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_hi && !(clr_stb && !hi_last)) |=> stat_hi);
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !hi_last && !hi_event) |=> !stat_hi);
  // R7
  clear_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !lo_last && !lo_event) |=> !stat_lo);
endmodule

bind temp_alert_queue tq_checker #(.TEMP_W(TEMP_W), .RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_temp(rd_temp),
  .lim_hi(lim_hi), .lim_lo(lim_lo), .clr_stb(clr_stb), .queue_on(queue_on),
  .stat_hi(stat_hi), .stat_lo(stat_lo), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
  .hi_last(hi_last), .hi_event(hi_event), .lo_event(lo_event), .lo_last(lo_last)
);

// File: tb/tb_temp_alert_queue.sv
module tb_temp_alert_queue;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rd_valid = 0;
  logic [7:0] rd_temp = '0;
  logic [7:0] lim_hi = '0;
  logic [7:0] lim_lo = '0;
  logic       cfg_we = 0;
  logic       cfg_wdata = 0;
  logic       clr_stb = 0;
  logic       stat_hi, stat_lo, alert;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  temp_alert_queue dut (.*);

  // reference model state
  int m_hi, m_lo, hi_run, lo_run;
  bit m_qen, m_sh, m_sl, m_lh, m_ll;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act={hi,lo,alert}=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic set_limits(input int h, input int l);
    @(negedge clk);
    lim_hi = h[7:0]; lim_lo = l[7:0];
    m_hi = h; m_lo = l;
  endtask

  task automatic send(input int t, input string tag);
    bit vh, vl;
    @(negedge clk);
    rd_temp = t[7:0]; rd_valid = 1;
    vh = t > m_hi; vl = t < m_lo;
    hi_run = vh ? hi_run + 1 : 0;
    lo_run = vl ? lo_run + 1 : 0;
    if (vh && (!m_qen || hi_run >= 3)) m_sh = 1;
    if (vl && (!m_qen || lo_run >= 3)) m_sl = 1;
    m_lh = vh; m_ll = vl;
    exp_q.push_back({m_sh, m_sl, m_sh | m_sl});
    tag_q.push_back(tag);
    @(negedge clk); rd_valid = 0;
  endtask

  task automatic set_cfg(input bit v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    m_qen = v;
    if (!v) begin hi_run = 0; lo_run = 0; end
  endtask

  task automatic do_clear(input string tag);
    @(negedge clk);
    clr_stb = 1;
    if (!m_lh) m_sh = 0;
    if (!m_ll) m_sl = 0;
    @(negedge clk);
    clr_stb = 0;
    check(tag, {stat_hi, stat_lo, alert}, {m_sh, m_sl, m_sh | m_sl});
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rd_valid && rst_n) begin
        #2;
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard act=unexpected exp=empty");
        end else
          check(tag_q.pop_front(), {stat_hi, stat_lo, alert}, exp_q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_qen = 0; m_sh = 0; m_sl = 0; m_lh = 0; m_ll = 0; hi_run = 0; lo_run = 0;
    m_hi = 0; m_lo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", {stat_hi, stat_lo, alert}, 3'b000);

    set_limits(50, -10);
    send(51, "R2 single high reading, filter off after reset (R1)");
    send(20, "R2 in-limit keeps latched bit");
    do_clear("R7 clear after in-limit reading");
    send(50, "R3 equal to high limit");
    send(-10, "R3 equal to low limit");
    send(-11, "R2 single low reading");
    send(-11, "R7 low stays set");
    do_clear("R7 clear refused while low condition present");
    send(0, "R7 in-limit reading");
    do_clear("R7 clear low after in-limit");

    set_cfg(1);
    send(60, "R4 first violation held (R8 enable)");
    send(60, "R4 second violation held");
    send(60, "R4 third violation sets");
    send(0, "R4 in-limit");
    do_clear("R7 clear high");

    send(-20, "R5 low run 1");
    send(-20, "R5 low run 2");
    send(0,   "R5 run broken");
    send(-20, "R5 low run restarts 1");
    send(-20, "R5 low run restarts 2");
    send(70,  "R5 high run independent 1");
    send(-20, "R5 low run 1 after high");
    send(-20, "R5 low run 2");
    send(-20, "R5 low run 3 sets");
    send(0,   "R5 in-limit");
    do_clear("R7 clear low");

    send(60, "R6 run 1");
    send(60, "R6 run 2");
    set_cfg(0);
    send(60, "R6 unfiltered after disable");
    send(0,  "R6 in-limit");
    do_clear("R7 clear high after disable test");

    set_cfg(1);
    send(60, "R6 runs start fresh after re-enable");

    set_cfg(0);
    set_limits(-5, -100);
    send(-5, "R3 signed equal negative limit");
    send(-4, "R3 signed above negative limit");
    send(-128, "R3 most negative reading");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard act=%0d pending exp=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule